// File: doc/BRIEF.md
# Link Repeater Discovery and Training-Mode Sequencer

This block runs once before link training on a display link. It works out how many link-training repeaters sit between the source and the sink, and it puts them into the right training mode. All traffic goes out as abstract register requests. Each request has an address, a length and a direction. A write also carries a data byte. Each request is held until the sideband channel returns an acknowledge with an ok/fail status and, for reads, the two bytes the sequencer needs.

A run begins with a start pulse. The sequencer first reads the repeater common-capability block, unless detection is suppressed. It then always reads the sink capabilities. If repeaters are present, it writes the transparent mode and then the non-transparent mode. If that succeeds, it reads one capability block for each repeater. The run ends with a one-cycle done pulse and a signed result. A positive result is the repeater count. Zero means the link trains in transparent mode. -1 means the sink capability read failed.

Top module: `rptr_seq`

## Requirements
- R1: When `skip_detect_i` is high at start, no common-capability read is issued. The first request is the sink read (address 0x00000, length 15), and the run behaves as if no repeaters exist.
- R2: The common-capability read goes to 0xF0000 with length 8. Its ack returns the structure revision in `ack_rdata_i[7:0]` and the count byte in `ack_rdata_i[15:8]`. A failed read, or a revision below 0x14, discards the block, so the count is zero.
- R3: The sink read always follows the detection attempt. If the sink read fails, the result is -1 and no further request is issued.
- R4: If the sink revision (`ack_rdata_i[7:0]`) is below 0x14, the result is 0 and no further request is issued.
- R5: If the count byte is zero, no mode write is issued and the result is 0.
- R6: Mode writes go to 0xF0003 with length 1. The transparent value is 0x55 and the non-transparent value is 0xAA. For a non-zero count, the transparent write comes first. The non-transparent write follows only when the count is valid.
- R7: An invalid count, or a failed non-transparent write, causes one more transparent write. The result is then 0 and no repeater read is issued.
- R8: After a successful non-transparent write, the repeater blocks are read in order for index 0 to n-1, at address 0xF0020 + index*0x50 with length 3. The result is n.
- R9: The count byte is decoded one-hot: 0x80 gives 1, 0x40 gives 2, and so on down to 0x01, which gives 8. Any other non-zero value is invalid.
- R10: `req_valid_o` and the request fields hold steady until `ack_i`. `busy_o` is high from the cycle after start until the run ends. `done_o` is a single-cycle pulse, and `result_o` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted when idle) |
| skip_detect_i | input | 1 | Suppress repeater detection for this run |
| req_valid_o | output | 1 | Request pending |
| req_write_o | output | 1 | 1 = write, 0 = read |
| req_addr_o | output | 20 | Register address |
| req_len_o | output | 8 | Transfer length in bytes |
| req_wdata_o | output | 8 | Write data byte |
| ack_i | input | 1 | Request completed (one cycle) |
| ack_ok_i | input | 1 | Completion status, 1 = ok |
| ack_rdata_i | input | 16 | Read bytes of interest: [7:0] revision, [15:8] count |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (one cycle) |
| result_o | output | 8 | Signed result: count, 0, or -1 |

## Verification
A wrong stored count or a wrong state shows up on the request port at the very next request. It appears as a mode write that should not occur, a missing transparent rewrite, or a repeater read at the wrong index. The stimulus therefore compares every request, in order, against an expected list, and the first divergence is caught one handshake after it happens. A wrong error or fallback decision also shows in `result_o` at the done pulse. The cases cover each revision check, each count boundary, an invalid count and a failing mode write.

// File: rtl/rptr_pkg.sv
package rptr_pkg;
  typedef enum logic [2:0] {
    RK_NONE, RK_COMMON, RK_SINK, RK_MODE_T, RK_MODE_NT, RK_PHY
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_COMMON, ST_SINK, ST_WR_T, ST_WR_NT, ST_WR_FB, ST_PHY
  } seq_state_e;
endpackage

// File: rtl/rptr_count_decode.sv
module rptr_count_decode #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned MAX_RPT = 8,
  parameter int unsigned CNT_W   = $clog2(MAX_RPT + 1)
) (
  input  logic [BYTE_W-1:0] raw_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              valid_o,
  output logic              zero_o
);
  localparam int unsigned NMAP = (MAX_RPT < BYTE_W) ? MAX_RPT : BYTE_W;

  logic [CNT_W-1:0] part [NMAP];

  // msb maps to 1, next bit to 2, ...
  for (genvar g = 0; g < NMAP; g++) begin : g_map
    assign part[g] = raw_i[BYTE_W-1-g] ? CNT_W'(g + 1) : '0;
  end

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < NMAP; i++) cnt_o = cnt_o | part[i];
  end

  assign zero_o  = (raw_i == '0);
  assign valid_o = $onehot(raw_i) && (cnt_o != '0);
endmodule

// File: rtl/rptr_req_gen.sv
module rptr_req_gen
  import rptr_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned LEN_W  = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 4,
  parameter logic [ADDR_W-1:0] COMMON_ADDR = 20'hF0000,
  parameter logic [ADDR_W-1:0] SINK_ADDR   = 20'h00000,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 20'hF0003,
  parameter logic [ADDR_W-1:0] PHY_BASE    = 20'hF0020,
  parameter int unsigned       PHY_STRIDE  = 'h50,
  parameter logic [LEN_W-1:0]  COMMON_LEN  = 8'd8,
  parameter logic [LEN_W-1:0]  SINK_LEN    = 8'd15,
  parameter logic [LEN_W-1:0]  PHY_LEN     = 8'd3,
  parameter logic [DATA_W-1:0] MODE_T      = 8'h55,
  parameter logic [DATA_W-1:0] MODE_NT     = 8'hAA
) (
  input  req_kind_e         kind_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic              valid_o,
  output logic              write_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic [ADDR_W-1:0] phy_off;
  assign phy_off = ADDR_W'(32'(idx_i) * PHY_STRIDE);

  always_comb begin
    valid_o = 1'b1;
    write_o = 1'b0;
    addr_o  = '0;
    len_o   = '0;
    wdata_o = '0;
    unique case (kind_i)
      RK_COMMON: begin addr_o = COMMON_ADDR; len_o = COMMON_LEN; end
      RK_SINK:   begin addr_o = SINK_ADDR;   len_o = SINK_LEN;   end
      RK_MODE_T: begin
        write_o = 1'b1; addr_o = MODE_ADDR; len_o = LEN_W'(1); wdata_o = MODE_T;
      end
      RK_MODE_NT: begin
        write_o = 1'b1; addr_o = MODE_ADDR; len_o = LEN_W'(1); wdata_o = MODE_NT;
      end
      RK_PHY:    begin addr_o = PHY_BASE + phy_off; len_o = PHY_LEN; end
      default:   valid_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/rptr_seq.sv
module rptr_seq
  import rptr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RES_W   = 8,
  parameter int unsigned MAX_RPT = 8,
  parameter logic [DATA_W-1:0] MIN_REV = 8'h14,
  parameter int          ERR_CODE    = -1,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 20'h00000,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 20'hF0003,
  parameter logic [DATA_W-1:0] MODE_T    = 8'h55,
  parameter logic [DATA_W-1:0] MODE_NT   = 8'hAA
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    skip_detect_i,
  output logic                    req_valid_o,
  output logic                    req_write_o,
  output logic [ADDR_W-1:0]       req_addr_o,
  output logic [LEN_W-1:0]        req_len_o,
  output logic [DATA_W-1:0]       req_wdata_o,
  input  logic                    ack_i,
  input  logic                    ack_ok_i,
  input  logic [2*DATA_W-1:0]     ack_rdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [RES_W-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(MAX_RPT + 1);

  seq_state_e        state_q;
  req_kind_e         kind;
  logic [DATA_W-1:0] raw_q;
  logic [CNT_W-1:0]  idx_q, cnt;
  logic              cnt_valid, cnt_zero, done_q;
  logic signed [RES_W-1:0] result_q;
  logic [DATA_W-1:0] rev_byte, cnt_byte;

  assign rev_byte = ack_rdata_i[DATA_W-1:0];
  assign cnt_byte = ack_rdata_i[2*DATA_W-1:DATA_W];

  rptr_count_decode #(.BYTE_W(DATA_W), .MAX_RPT(MAX_RPT), .CNT_W(CNT_W)) u_dec (
    .raw_i(raw_q), .cnt_o(cnt), .valid_o(cnt_valid), .zero_o(cnt_zero)
  );

  always_comb begin
    unique case (state_q)
      ST_COMMON: kind = RK_COMMON;
      ST_SINK:   kind = RK_SINK;
      ST_WR_T,
      ST_WR_FB:  kind = RK_MODE_T;
      ST_WR_NT:  kind = RK_MODE_NT;
      ST_PHY:    kind = RK_PHY;
      default:   kind = RK_NONE;
    endcase
  end

  rptr_req_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .SINK_ADDR(SINK_ADDR), .MODE_ADDR(MODE_ADDR), .MODE_T(MODE_T), .MODE_NT(MODE_NT)
  ) u_req (
    .kind_i(kind), .idx_i(idx_q), .valid_o(req_valid_o), .write_o(req_write_o),
    .addr_o(req_addr_o), .len_o(req_len_o), .wdata_o(req_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      raw_q    <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          idx_q <= '0;
          raw_q <= '0;
          state_q <= skip_detect_i ? ST_SINK : ST_COMMON;
        end
        ST_COMMON: if (ack_i) begin
          // a failed or too-old block counts as no repeaters
          raw_q   <= (ack_ok_i && rev_byte >= MIN_REV) ? cnt_byte : '0;
          state_q <= ST_SINK;
        end
        ST_SINK: if (ack_i) begin
          if (!ack_ok_i || rev_byte < MIN_REV || cnt_zero) begin
            raw_q    <= '0;
            result_q <= ack_ok_i ? '0 : RES_W'(ERR_CODE);
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            state_q <= ST_WR_T;
          end
        end
        ST_WR_T: if (ack_i) state_q <= cnt_valid ? ST_WR_NT : ST_WR_FB;
        ST_WR_NT: if (ack_i) begin
          idx_q   <= '0;
          state_q <= ack_ok_i ? ST_PHY : ST_WR_FB;
        end
        ST_WR_FB: if (ack_i) begin
          raw_q    <= '0;
          result_q <= '0;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_PHY: if (ack_i) begin
          if (idx_q == cnt - CNT_W'(1)) begin
            result_q <= RES_W'(cnt);
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/rptr_seq_chk.sv
module rptr_seq_chk #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned LEN_W   = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned RES_W   = 8,
  parameter int unsigned MAX_RPT = 8,
  parameter int          ERR_CODE = -1,
  parameter logic [ADDR_W-1:0] SINK_ADDR = 20'h00000,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 20'hF0003,
  parameter logic [DATA_W-1:0] MODE_T    = 8'h55,
  parameter logic [DATA_W-1:0] MODE_NT   = 8'hAA
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    skip_detect_i,
  input logic                    req_valid_o,
  input logic                    req_write_o,
  input logic [ADDR_W-1:0]       req_addr_o,
  input logic [LEN_W-1:0]        req_len_o,
  input logic [DATA_W-1:0]       req_wdata_o,
  input logic                    ack_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic signed [RES_W-1:0] result_o
);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !ack_i |=> req_valid_o && $stable(req_addr_o)
                              && $stable(req_write_o) && $stable(req_len_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_req_in_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> busy_o);

  assert_write_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && req_write_o |->
      req_addr_o == MODE_ADDR && (req_wdata_o == MODE_T || req_wdata_o == MODE_NT));

  assert_skip_to_sink_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && skip_detect_i |=>
      req_valid_o && !req_write_o && req_addr_o == SINK_ADDR);

  assert_result_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (int'(result_o) >= ERR_CODE) && (int'(result_o) <= int'(MAX_RPT)));
endmodule

bind rptr_seq rptr_seq_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .RES_W(RES_W), .MAX_RPT(MAX_RPT),
  .ERR_CODE(ERR_CODE), .SINK_ADDR(SINK_ADDR), .MODE_ADDR(MODE_ADDR),
  .MODE_T(MODE_T), .MODE_NT(MODE_NT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .skip_detect_i(skip_detect_i),
  .req_valid_o(req_valid_o), .req_write_o(req_write_o), .req_addr_o(req_addr_o),
  .req_len_o(req_len_o), .req_wdata_o(req_wdata_o), .ack_i(ack_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o)
);

// File: tb/rptr_seq_tb.sv
module rptr_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start, skip, ack, ack_ok;
  logic [15:0] rdata;
  logic        req_valid, req_write, busy, done;
  logic [19:0] req_addr;
  logic [7:0]  req_len, req_wdata;
  logic signed [7:0] result;

  rptr_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .skip_detect_i(skip),
    .req_valid_o(req_valid), .req_write_o(req_write), .req_addr_o(req_addr),
    .req_len_o(req_len), .req_wdata_o(req_wdata), .ack_i(ack), .ack_ok_i(ack_ok),
    .ack_rdata_i(rdata), .busy_o(busy), .done_o(done), .result_o(result)
  );

  typedef struct packed {
    logic [19:0] addr;
    logic        wr;
    logic [7:0]  len;
    logic [7:0]  wd;
  } item_t;

  item_t exp_q[$];
  int    n_cmp = 0, n_bad = 0, n_req = 0;
  string tag = "R0";

  // channel behaviour for the current case
  logic       c_common_ok, c_sink_ok, c_nt_ok;
  logic [7:0] c_common_rev, c_cnt, c_sink_rev;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push_req(input logic [19:0] a, input logic w, input logic [7:0] l,
                          input logic [7:0] d);
    item_t it;
    it.addr = a; it.wr = w; it.len = l; it.wd = d;
    exp_q.push_back(it);
  endtask

  task automatic push_phys(input int n);
    for (int i = 0; i < n; i++) push_req(20'hF0020 + 20'(i * 'h50), 1'b0, 8'd3, 8'h00);
  endtask

  // monitor and sideband model: pops expected requests and answers them
  initial begin
    ack = 1'b0; ack_ok = 1'b0; rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && req_valid) begin
        item_t it;
        n_req++;
        if (exp_q.size() == 0) begin
          check(1'b0, tag, "unexpected request addr", longint'(req_addr), 0);
        end else begin
          it = exp_q.pop_front();
          check(req_addr == it.addr, tag, "request addr", longint'(req_addr), longint'(it.addr));
          check(req_write == it.wr && req_len == it.len, tag, "request dir/len",
                longint'({req_write, req_len}), longint'({it.wr, it.len}));
          if (it.wr) check(req_wdata == it.wd, tag, "write data",
                           longint'(req_wdata), longint'(it.wd));
        end
        repeat (n_req % 3) @(negedge clk);
        ack_ok = 1'b1; rdata = 16'h0;
        if (req_write) ack_ok = (req_wdata == 8'hAA) ? c_nt_ok : 1'b1;
        else if (req_addr == 20'hF0000) begin ack_ok = c_common_ok; rdata = {c_cnt, c_common_rev}; end
        else if (req_addr == 20'h00000) begin ack_ok = c_sink_ok; rdata = {8'h00, c_sink_rev}; end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end

  task automatic run_case(input string t, input logic sk, input logic cok, input logic [7:0] crev,
                          input logic [7:0] cnt, input logic sok, input logic [7:0] srev,
                          input logic ntok, input int exp_res);
    tag = t;
    c_common_ok = cok; c_common_rev = crev; c_cnt = cnt;
    c_sink_ok = sok; c_sink_rev = srev; c_nt_ok = ntok;
    @(negedge clk);
    skip = sk; start = 1'b1;
    @(negedge clk);
    start = 1'b0; skip = 1'b0;
    check(busy == 1'b1, "R10", "busy after start", longint'(busy), 1);
    while (!done) @(negedge clk);
    check(int'(result) == exp_res, t, "result", longint'(result), longint'(exp_res));
    check(exp_q.size() == 0, t, "missing requests", longint'(exp_q.size()), 0);
    exp_q.delete();
    @(negedge clk);
    check(!done && !busy, "R10", "done pulse width", longint'({done, busy}), 0);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; skip = 1'b0;
    c_common_ok = 1'b1; c_sink_ok = 1'b1; c_nt_ok = 1'b1;
    c_common_rev = 8'h14; c_cnt = 8'h00; c_sink_rev = 8'h14;
    repeat (3) @(negedge clk);
    check(!busy && !done && !req_valid && result == 0, "R10", "reset state",
          longint'({busy, done, req_valid, result}), 0);
    rst_n = 1'b1;

    // R1: detection skipped, only sink read, count treated zero
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    run_case("R1", 1'b1, 1'b1, 8'h14, 8'h80, 1'b1, 8'h14, 1'b1, 0);

    // R2: old common revision discards a valid count
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    run_case("R2", 1'b0, 1'b1, 8'h13, 8'h80, 1'b1, 8'h14, 1'b1, 0);

    // R2: failed common read
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    run_case("R2", 1'b0, 1'b0, 8'h14, 8'h40, 1'b1, 8'h14, 1'b1, 0);

    // R3: sink read fails -> error code
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    run_case("R3", 1'b0, 1'b1, 8'h14, 8'h40, 1'b0, 8'h14, 1'b1, -1);

    // R4: sink revision too old
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    run_case("R4", 1'b0, 1'b1, 8'h14, 8'h40, 1'b1, 8'h12, 1'b1, 0);

    // R5: zero count, no mode write
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    run_case("R5", 1'b0, 1'b1, 8'h14, 8'h00, 1'b1, 8'h14, 1'b1, 0);

    // R6 R8 R9: count byte 0x20 -> 3 repeaters
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    push_req(20'hF0003, 1'b1, 8'd1, 8'hAA);
    push_phys(3);
    run_case("R8", 1'b0, 1'b1, 8'h14, 8'h20, 1'b1, 8'h14, 1'b1, 3);

    // R9: 0x80 -> 1
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    push_req(20'hF0003, 1'b1, 8'd1, 8'hAA);
    push_phys(1);
    run_case("R9", 1'b0, 1'b1, 8'h14, 8'h80, 1'b1, 8'h14, 1'b1, 1);

    // R9: 0x01 -> 8, upper boundary
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    push_req(20'hF0003, 1'b1, 8'd1, 8'hAA);
    push_phys(8);
    run_case("R9", 1'b0, 1'b1, 8'h20, 8'h01, 1'b1, 8'h14, 1'b1, 8);

    // R7: invalid count byte -> transparent twice
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    run_case("R7", 1'b0, 1'b1, 8'h14, 8'h03, 1'b1, 8'h14, 1'b1, 0);

    // R7: non-transparent write fails
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    push_req(20'hF0003, 1'b1, 8'd1, 8'hAA);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    run_case("R7", 1'b0, 1'b1, 8'h14, 8'h10, 1'b1, 8'h14, 1'b0, 0);

    // R6: rerun after fallback works normally (count 0x40 -> 2)
    push_req(20'hF0000, 1'b0, 8'd8, 8'h00);
    push_req(20'h00000, 1'b0, 8'd15, 8'h00);
    push_req(20'hF0003, 1'b1, 8'd1, 8'h55);
    push_req(20'hF0003, 1'b1, 8'd1, 8'hAA);
    push_phys(2);
    run_case("R6", 1'b0, 1'b1, 8'h14, 8'h40, 1'b1, 8'h14, 1'b1, 2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule